// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral on a simple word-addressed register bus. A 12-bit down-counter is decremented by a slow tick strobe, 256 strobes per second. Software keeps it from running out by writing a restart command, and that command is accepted only when it carries an 8-bit key in the same bus word. If the count runs out, the expiry goes to one of two places, chosen in the mode register: a level interrupt or a one-cycle system reset request.

Software can stop the counter with a disable bit. While that bit is set, the count and window fields are locked against writes. Two further mode bits freeze counting while the processor is idle or halted in debug. A status register latches every expiry, and reading it clears the latch.

The default timeout is 16 seconds, which is 16*256-1 = 4095 ticks. The tick count for N seconds is N*256-1, or 0 for N = 0, saturated to the field width.

Top module: `wdog_periph`

## Requirements
- R1: After reset, the mode register reads 0x0FFF_2FFF (reload 4095, window 4095, reset routing on, counter running), the status register reads 0, and `fault_irq` and `sys_rst_req` are low.
- R2: The mode register sits at byte offset 0x0 and reads back what was accepted. Its fields are: reload value at bits 11:0, window value at 27:16, fault-interrupt enable at bit 12, reset enable at bit 13, disable at bit 15, idle freeze at bit 28 and debug freeze at bit 29. Every accepted mode write loads the counter with the resulting reload value.
- R3: Each counted tick decrements the counter. A counted tick that finds the counter at 0 is an expiry and reloads it, so a reload value V expires on the (V+1)-th counted tick.
- R4: A write to the control register at offset 0x4 restarts the counter from the reload value when bits 31:24 equal 0xA5 and bit 0 is 1. A restart wins over a tick in the same cycle.
- R5: A control write with a wrong key, or with bit 0 clear, changes nothing.
- R6: While the disable bit is set, ticks do not count and no expiry occurs. A write that clears the bit starts the counter again and keeps the other accepted fields.
- R7: While the disable bit is currently set, the reload and window fields of a mode write are ignored and its other bits are taken. Changing those fields needs a prior write that clears the disable bit.
- R8: On expiry, fault-interrupt enable raises `fault_irq`. Otherwise, reset enable gives a one-cycle `sys_rst_req` pulse in the cycle after the expiring tick. Fault routing takes precedence over reset routing.
- R9: Status bit 0 (offset 0x8) sets on every expiry, whatever the routing. A status read returns it and clears it. `fault_irq` equals that bit ANDed with fault-interrupt enable, so it stays high until the read.
- R10: With idle freeze set, ticks are ignored while `cpu_idle` is high. With debug freeze set, ticks are ignored while `cpu_debug` is high. Each input has no effect while its freeze bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_rd | input | 1 | Read strobe (with bus_sel); a status read clears the expiry flag |
| bus_addr | input | 4 | Byte address: 0x0 mode, 0x4 control, 0x8 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| slow_tick | input | 1 | One-cycle strobe, 256 per second |
| cpu_idle | input | 1 | Processor idle indication |
| cpu_debug | input | 1 | Processor debug-halt indication |
| fault_irq | output | 1 | Expiry interrupt, level |
| sys_rst_req | output | 1 | Expiry reset request, one-cycle pulse |

## Verification
Some properties are checked on every cycle:
- A counted tick away from zero decrements the counter by exactly one.
- The counter holds while the block is disabled.
- Window and reload fields stay put under a write made while disabled.
- The interrupt never shows without the latched flag.
- A status read with no competing expiry clears the flag.
- Every reset request follows an expiry with fault routing off.

The bench scenarios cover what these properties cannot:
- the exact expiry tick for a given reload value;
- key acceptance and rejection;
- the two-write unlock order;
- routing precedence;
- freeze gating by each input;
- the full 4096-tick default timeout after reset.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the watchdog peripheral.
// Assumes the field positions below are fixed by software and must not move.
package wdog_pkg;
    localparam int WORD_W      = 32;
    localparam int FIELD_W     = 12;
    localparam int RELOAD_LSB  = 0;
    localparam int WINDOW_LSB  = 16;
    localparam int FAULT_BIT   = 12;
    localparam int RSTEN_BIT   = 13;
    localparam int DIS_BIT     = 15;
    localparam int IDLE_BIT    = 28;
    localparam int DBG_BIT     = 29;
    localparam int KEY_LSB     = 24;
    localparam int KEY_W       = 8;
    localparam logic [KEY_W-1:0] KEY_VAL = 8'hA5;
    localparam int RESTART_BIT = 0;
    localparam logic [1:0] IDX_MODE = 2'd0;
    localparam logic [1:0] IDX_CTRL = 2'd1;
    localparam logic [1:0] IDX_STAT = 2'd2;

    typedef struct packed {
        logic               idle_frz;
        logic               dbg_frz;
        logic               fault_en;
        logic               rst_en;
        logic               disabled;
        logic [FIELD_W-1:0] window;
        logic [FIELD_W-1:0] reload;
    } mode_t;

    // Ticks for a timeout of secs seconds, saturated to the field width.
    function automatic logic [FIELD_W-1:0] secs_to_ticks(input int secs, input int per_sec);
        longint raw;
        raw = (secs == 0) ? 0 : longint'(secs) * longint'(per_sec) - 1;
        if (raw > longint'((1 << FIELD_W) - 1)) raw = longint'((1 << FIELD_W) - 1);
        return FIELD_W'(raw);
    endfunction

    // Places the mode fields at their register bit positions.
    function automatic logic [WORD_W-1:0] pack_mode(input mode_t m);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RELOAD_LSB +: FIELD_W] = m.reload;
        w[WINDOW_LSB +: FIELD_W] = m.window;
        w[FAULT_BIT] = m.fault_en;
        w[RSTEN_BIT] = m.rst_en;
        w[DIS_BIT]   = m.disabled;
        w[IDLE_BIT]  = m.idle_frz;
        w[DBG_BIT]   = m.dbg_frz;
        return w;
    endfunction
endpackage

// File: rtl/wdog_regbank.sv
`timescale 1ns/1ps
// Register bank: mode register with disable lock, key-checked restart decode,
// and the read multiplexer. Assumes word-aligned byte addresses.
module wdog_regbank
    import wdog_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RST_TICKS = 12'hFFF,
    parameter int                 ADDR_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               stat_flag,
    output mode_t              mode,
    output logic               mode_wr,
    output logic               restart,
    output logic               stat_rd,
    output logic [FIELD_W-1:0] load_val,
    output logic [WORD_W-1:0]  rdata
);
    localparam int IDX_LSB = 2;

    logic [1:0] idx;
    logic       unused_bits;

    assign idx         = addr[IDX_LSB +: 2];
    assign unused_bits = ^{addr[1:0], wdata[14]};

    // Decode the bus strobes per register.
    assign mode_wr = sel && wr && (idx == IDX_MODE);
    assign stat_rd = sel && rd && (idx == IDX_STAT);
    assign restart = sel && wr && (idx == IDX_CTRL)
                  && (wdata[KEY_LSB +: KEY_W] == KEY_VAL) && wdata[RESTART_BIT];

    // Counter load value: the reload the mode register holds after this edge.
    assign load_val = (mode_wr && !mode.disabled) ? wdata[RELOAD_LSB +: FIELD_W] : mode.reload;

    // Mode register update; count fields locked while currently disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode          <= '0;
            mode.reload   <= RST_TICKS;
            mode.window   <= RST_TICKS;
            mode.rst_en   <= 1'b1;
        end else if (mode_wr) begin
            mode.disabled <= wdata[DIS_BIT];
            mode.fault_en <= wdata[FAULT_BIT];
            mode.rst_en   <= wdata[RSTEN_BIT];
            mode.idle_frz <= wdata[IDLE_BIT];
            mode.dbg_frz  <= wdata[DBG_BIT];
            if (!mode.disabled) begin
                mode.reload <= wdata[RELOAD_LSB +: FIELD_W];
                mode.window <= wdata[WINDOW_LSB +: FIELD_W];
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (idx == IDX_MODE) rdata = pack_mode(mode);
        else if (idx == IDX_STAT) rdata[0] = stat_flag;
    end
endmodule

// File: rtl/wdog_downcount.sv
`timescale 1ns/1ps
// Down-counter: decrements on gated ticks, flags expiry at zero and reloads.
// Assumes slow_tick is a one-cycle strobe in the clk domain.
module wdog_downcount
    import wdog_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RST_TICKS = 12'hFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               idle_in,
    input  logic               dbg_in,
    input  mode_t              mode,
    input  logic               load,
    input  logic [FIELD_W-1:0] load_val,
    output logic [FIELD_W-1:0] cnt,
    output logic               run,
    output logic               expire
);
    // Tick gating by disable and the two freeze conditions.
    assign run = tick && !mode.disabled
              && !(mode.idle_frz && idle_in)
              && !(mode.dbg_frz && dbg_in);

    // A load (restart or mode write) overrides a coincident expiry.
    assign expire = run && (cnt == '0) && !load;

    // Counter state.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= RST_TICKS;
        else if (load)     cnt <= load_val;
        else if (run)      cnt <= (cnt == '0) ? mode.reload : cnt - 1'b1;
    end
endmodule

// File: rtl/wdog_status.sv
`timescale 1ns/1ps
// Expiry flag, interrupt level and reset-request pulse.
// Assumes a set by expiry wins over a clear by read in the same cycle.
module wdog_status (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic stat_rd,
    input  logic fault_en,
    input  logic rst_en,
    output logic flag,
    output logic irq,
    output logic rst_req
);
    // Sticky expiry flag, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (expire)  flag <= 1'b1;
        else if (stat_rd) flag <= 1'b0;
    end

    // Reset request pulse when fault routing is off.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= expire && !fault_en && rst_en;
    end

    assign irq = flag && fault_en;
endmodule

// File: rtl/wdog_periph.sv
`timescale 1ns/1ps
// Watchdog peripheral top: register bank, down-counter, status/outputs.
// Assumes TICKS_PER_S strobes per second on slow_tick.
module wdog_periph
    import wdog_pkg::*;
#(
    parameter int TIMEOUT_S   = 16,
    parameter int TICKS_PER_S = 256,
    parameter int ADDR_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              slow_tick,
    input  logic              cpu_idle,
    input  logic              cpu_debug,
    output logic              fault_irq,
    output logic              sys_rst_req
);
    localparam logic [FIELD_W-1:0] RST_TICKS = secs_to_ticks(TIMEOUT_S, TICKS_PER_S);

    mode_t              mode_q;
    logic               mode_wr, restart, stat_rd, stat_flag;
    logic               cnt_run, expire, cnt_load;
    logic [FIELD_W-1:0] load_val, cnt_q;

    assign cnt_load = mode_wr || restart;

    wdog_regbank #(.RST_TICKS(RST_TICKS), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .stat_flag(stat_flag),
        .mode(mode_q), .mode_wr(mode_wr), .restart(restart), .stat_rd(stat_rd),
        .load_val(load_val), .rdata(bus_rdata)
    );

    wdog_downcount #(.RST_TICKS(RST_TICKS)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(slow_tick), .idle_in(cpu_idle),
        .dbg_in(cpu_debug), .mode(mode_q), .load(cnt_load), .load_val(load_val),
        .cnt(cnt_q), .run(cnt_run), .expire(expire)
    );

    wdog_status stat_i (
        .clk(clk), .rst_n(rst_n), .expire(expire), .stat_rd(stat_rd),
        .fault_en(mode_q.fault_en), .rst_en(mode_q.rst_en),
        .flag(stat_flag), .irq(fault_irq), .rst_req(sys_rst_req)
    );
endmodule

// File: rtl/wdog_periph_chk.sv
`timescale 1ns/1ps
// Cycle-level properties of the watchdog, bound into wdog_periph.
module wdog_periph_chk #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] reload,
    input logic          run,
    input logic          load,
    input logic          expire,
    input logic          disabled,
    input logic          mode_wr,
    input logic          fault_en,
    input logic          flag,
    input logic          stat_rd,
    input logic          irq,
    input logic          rst_req
);
    assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_frozen_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (disabled && !load) |=> $stable(cnt));

    assert_fields_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && disabled) |=> $stable(reload));

    assert_reset_after_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(expire) && !$past(fault_en)));

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !expire) |=> !flag);
endmodule

bind wdog_periph wdog_periph_chk #(.CW(wdog_pkg::FIELD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .reload(mode_q.reload),
    .run(cnt_run), .load(cnt_load), .expire(expire), .disabled(mode_q.disabled),
    .mode_wr(mode_wr), .fault_en(mode_q.fault_en), .flag(stat_flag),
    .stat_rd(stat_rd), .irq(fault_irq), .rst_req(sys_rst_req)
);

// File: tb/wdog_periph_tb.sv
`timescale 1ns/1ps
// Self-checking bench: vector table walk, then directed reset/corner tests.
module wdog_periph_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] OP_RM = 3'd0, OP_RS = 3'd1, OP_WM = 3'd2, OP_WC = 3'd3, OP_TK = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // exp for OP_TK is {30'b0, sys_rst_req, fault_irq}; data[0]=idle, data[1]=debug.
    localparam int NV = 62;
    localparam vec_t VECS [0:NV-1] = '{
        '{OP_RM, 32'h0, 32'h0FFF2FFF, 8'd1},  // R1 reset mode value
        '{OP_RS, 32'h0, 32'h0, 8'd1},         // R1 status clear
        '{OP_WM, 32'h00001003, 32'h0, 8'd2},  // R2
        '{OP_RM, 32'h0, 32'h00001003, 8'd2},  // R2 readback
        '{OP_TK, 32'h0, 32'h0, 8'd3},         // R3 3->2
        '{OP_TK, 32'h0, 32'h0, 8'd3},
        '{OP_TK, 32'h0, 32'h0, 8'd3},
        '{OP_TK, 32'h0, 32'h1, 8'd3},         // R3 fourth tick expires
        '{OP_TK, 32'h0, 32'h1, 8'd9},         // R9 irq held
        '{OP_RS, 32'h0, 32'h1, 8'd9},
        '{OP_TK, 32'h0, 32'h0, 8'd9},         // R9 irq gone after read
        '{OP_WM, 32'h00002001, 32'h0, 8'd8},  // R8 reset routing
        '{OP_TK, 32'h0, 32'h0, 8'd8},
        '{OP_TK, 32'h0, 32'h2, 8'd8},
        '{OP_TK, 32'h0, 32'h0, 8'd8},         // R8 one-cycle pulse
        '{OP_RS, 32'h0, 32'h1, 8'd9},
        '{OP_WM, 32'h00003000, 32'h0, 8'd8},  // R8 both enabled
        '{OP_TK, 32'h0, 32'h1, 8'd8},         // R8 fault wins
        '{OP_RS, 32'h0, 32'h1, 8'd9},
        '{OP_WM, 32'h00001002, 32'h0, 8'd4},  // R4
        '{OP_TK, 32'h0, 32'h0, 8'd4},
        '{OP_TK, 32'h0, 32'h0, 8'd4},
        '{OP_WC, 32'hA5000001, 32'h0, 8'd4},  // R4 keyed restart
        '{OP_TK, 32'h0, 32'h0, 8'd4},
        '{OP_TK, 32'h0, 32'h0, 8'd4},
        '{OP_TK, 32'h0, 32'h1, 8'd4},
        '{OP_RS, 32'h0, 32'h1, 8'd4},
        '{OP_WM, 32'h00001001, 32'h0, 8'd5},  // R5
        '{OP_TK, 32'h0, 32'h0, 8'd5},
        '{OP_WC, 32'h5A000001, 32'h0, 8'd5},  // R5 wrong key
        '{OP_TK, 32'h0, 32'h1, 8'd5},
        '{OP_RS, 32'h0, 32'h1, 8'd5},
        '{OP_WM, 32'h00001001, 32'h0, 8'd5},
        '{OP_TK, 32'h0, 32'h0, 8'd5},
        '{OP_WC, 32'hA5000000, 32'h0, 8'd5},  // R5 restart bit clear
        '{OP_TK, 32'h0, 32'h1, 8'd5},
        '{OP_RS, 32'h0, 32'h1, 8'd5},
        '{OP_WM, 32'h00059000, 32'h0, 8'd6},  // R6 disable
        '{OP_RM, 32'h0, 32'h00059000, 8'd6},
        '{OP_TK, 32'h0, 32'h0, 8'd6},         // R6 no expiry at 0
        '{OP_TK, 32'h0, 32'h0, 8'd6},
        '{OP_WM, 32'h00079007, 32'h0, 8'd7},  // R7 locked
        '{OP_RM, 32'h0, 32'h00059000, 8'd7},
        '{OP_WM, 32'h00071007, 32'h0, 8'd7},  // R7 unlock write
        '{OP_RM, 32'h0, 32'h00051000, 8'd7},
        '{OP_TK, 32'h0, 32'h1, 8'd6},         // R6 running again
        '{OP_RS, 32'h0, 32'h1, 8'd6},
        '{OP_WM, 32'h00071007, 32'h0, 8'd7},
        '{OP_RM, 32'h0, 32'h00071007, 8'd7},  // R7 now accepted
        '{OP_WM, 32'h10001000, 32'h0, 8'd10}, // R10 idle freeze
        '{OP_TK, 32'h1, 32'h0, 8'd10},
        '{OP_TK, 32'h1, 32'h0, 8'd10},
        '{OP_TK, 32'h0, 32'h1, 8'd10},
        '{OP_RS, 32'h0, 32'h1, 8'd10},
        '{OP_WM, 32'h20001000, 32'h0, 8'd10}, // R10 debug freeze
        '{OP_TK, 32'h2, 32'h0, 8'd10},
        '{OP_TK, 32'h1, 32'h1, 8'd10},        // R10 idle ignored here
        '{OP_RS, 32'h0, 32'h1, 8'd10},
        '{OP_WM, 32'h00000000, 32'h0, 8'd8},  // R8 no routing
        '{OP_TK, 32'h0, 32'h0, 8'd8},
        '{OP_RS, 32'h0, 32'h1, 8'd9},         // R9 flag regardless
        '{OP_RS, 32'h0, 32'h0, 8'd9}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        slow_tick = 1'b0, cpu_idle = 1'b0, cpu_debug = 1'b0;
    logic        fault_irq, sys_rst_req;
    int          checks = 0, failures = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_periph dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slow_tick(slow_tick), .cpu_idle(cpu_idle), .cpu_debug(cpu_debug),
        .fault_irq(fault_irq), .sys_rst_req(sys_rst_req)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
        slow_tick = 0; cpu_idle = 0; cpu_debug = 0;
    endtask

    // One operation per clock: drive at negedge, sample reads before the edge,
    // sample outputs one negedge after the edge.
    task automatic run_op(input vec_t v);
        case (v.op)
            OP_RM: begin bus_sel = 1; bus_rd = 1; bus_addr = 4'h0; end
            OP_RS: begin bus_sel = 1; bus_rd = 1; bus_addr = 4'h8; end
            OP_WM: begin bus_sel = 1; bus_wr = 1; bus_addr = 4'h0; bus_wdata = v.data; end
            OP_WC: begin bus_sel = 1; bus_wr = 1; bus_addr = 4'h4; bus_wdata = v.data; end
            default: begin slow_tick = 1; cpu_idle = v.data[0]; cpu_debug = v.data[1]; end
        endcase
        #1;
        if (v.op == OP_RM || v.op == OP_RS) check(int'(v.req), bus_rdata, v.exp);
        @(posedge clk);
        @(negedge clk);
        idle_bus();
        if (v.op == OP_TK) check(int'(v.req), {30'b0, sys_rst_req, fault_irq}, v.exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle_bus();
        repeat (3) @(negedge clk);
        rst_n = 1;
        check(1, {30'b0, sys_rst_req, fault_irq}, 32'h0); // R1 outputs low

        for (int i = 0; i < NV; i++) run_op(VECS[i]);

        // R4: restart and tick in the same cycle, restart wins.
        run_op('{OP_WM, 32'h00001001, 32'h0, 8'd4});
        run_op('{OP_TK, 32'h0, 32'h0, 8'd4});
        bus_sel = 1; bus_wr = 1; bus_addr = 4'h4; bus_wdata = 32'hA5000001; slow_tick = 1;
        @(posedge clk); @(negedge clk); idle_bus();
        check(4, {31'b0, fault_irq}, 32'h0);
        run_op('{OP_TK, 32'h0, 32'h0, 8'd4});
        run_op('{OP_TK, 32'h0, 32'h1, 8'd4});

        // R1: reset in the middle of a pending interrupt.
        rst_n = 0;
        repeat (2) @(negedge clk);
        check(1, {30'b0, sys_rst_req, fault_irq}, 32'h0);
        rst_n = 1;
        run_op('{OP_RM, 32'h0, 32'h0FFF2FFF, 8'd1});
        run_op('{OP_RS, 32'h0, 32'h0, 8'd1});

        // R3/R1: default reload 4095 expires on tick 4096 with a reset pulse.
        begin
            int early = 0;
            for (int t = 0; t < 4095; t++) begin
                slow_tick = 1;
                @(posedge clk); @(negedge clk);
                if (sys_rst_req) early++;
            end
            check(3, early, 0);
            @(posedge clk); @(negedge clk);
            check(3, {31'b0, sys_rst_req}, 32'h1);
            slow_tick = 0;
        end

        finish_run();
    end
endmodule